// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Unit

This block holds the interrupt logic of one peripheral that sits in a priority chain of interrupting devices. The neighbour above it supplies a chain-enable input. The block passes a chain-enable output to the neighbour below. It collects local request lines into a pending flag. It asserts an active-low request to the CPU when it may do so.

When the CPU runs an interrupt acknowledge cycle, the block decides at the first clock of that cycle whether it wins. A winning unit drives its stored 8-bit vector on the data bus for the rest of the cycle. It then enters an in-service state, which holds the chain below it closed. The chain stays closed until a return-from-interrupt indication arrives while the chain above is open. Software writes the vector through a load strobe, and the lowest bit of the stored vector is always zero.

Top module: `irq_chain_node`

## Requirements
- R1: During and right after synchronous reset (`rst` high), the outputs are as follows: `int_n`=1, `dout_en`=0, `dout`=0, and `ie_out` equals `ie_in`. The stored vector is 0 and nothing is pending or in service.
- R2: `ie_out` is 0 in every cycle in which `ie_in` is 0.
- R3: Any `src_req` bit high at a clock edge sets the pending flag. `int_n` is 0 from the next cycle on, but only while `ie_in` is 1 and the unit is not in service. `int_n` is 1 whenever `ie_in` is 0.
- R4: While a request is pending and not yet acknowledged, `ie_out` is 0.
- R5: An acknowledge cycle is `iorq_n`=0, `m1_n`=0 and `rd_n`=1 together. M1 alone, and I/O request with read active, are not acknowledges. In the first cycle of an acknowledge, the unit responds if it is pending, `ie_in` is 1 and it is not in service. It then drives `dout_en`=1 and `dout`=vector for every cycle of that acknowledge.
- R6: After responding, the unit is in service from the next cycle. While in service, `ie_out` is 0 and `int_n` is 1, even if a new request is pending.
- R7: `reti_seen` in a cycle with `ie_in`=1 ends service from the next cycle, which reopens `ie_out`. `reti_seen` with `ie_in`=0 is ignored.
- R8: `vec_ld`=1 stores `cpu_din` with bit 0 forced to 0. That value is what appears on `dout` in a later response.
- R9: Outside a responding acknowledge, `dout_en` is 0 and `dout` is 0. The unit does not respond in three cases: no request is pending, `ie_in` is 0 in the acknowledge's first cycle, or the request becomes eligible only after the acknowledge has started.
- R10: A `src_req` that arrives in the same cycle in which the unit responds is absorbed. No request remains pending after that service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | NSRC | Local interrupt sources, any bit high requests |
| ie_in | input | 1 | Chain enable from the higher-priority neighbour |
| iorq_n | input | 1 | CPU I/O request, active low |
| m1_n | input | 1 | CPU M1 cycle, active low |
| rd_n | input | 1 | CPU read, active low |
| vec_ld | input | 1 | Vector load strobe |
| cpu_din | input | VW | CPU data bus, written to the vector |
| reti_seen | input | 1 | Return-from-interrupt decoded on the bus |
| ie_out | output | 1 | Chain enable to the lower-priority neighbour |
| int_n | output | 1 | Interrupt request to the CPU, active low |
| dout | output | VW | Vector toward the CPU data bus |
| dout_en | output | 1 | Data bus drive enable |

## Verification
The bench starts an acknowledge while the chain above is closed and then opens the chain in the middle of that acknowledge. A unit that decides on every acknowledge cycle instead of only the first would wrongly seize the bus partway through. Return-from-interrupt is sent while `ie_in` is low. A unit that ignored the chain gate here would close its service early and reopen the chain below under a device still being serviced. A source that pulses in the responding cycle checks that the request is absorbed, because a wrong unit would raise a spurious second request. Decoding the acknowledge is checked with M1 alone and with read active. A sloppy decoder would put the vector onto an opcode fetch or an I/O read. A vector written with bit 0 set checks that the forced zero reaches the bus.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    localparam int unsigned VEC_W_DEF = 8;
    localparam int unsigned NSRC_DEF  = 4;

    // Per-unit control state
    typedef struct packed {
        logic pend;    // request waiting for acknowledge
        logic in_srv;  // service routine under way
        logic claim;   // this unit owns the current acknowledge
        logic ack_d;   // acknowledge seen in previous cycle
    } irq_ctx_t;

    function automatic logic ack_decode(input logic iorq_n,
                                        input logic m1_n,
                                        input logic rd_n);
        return !iorq_n && !m1_n && rd_n;
    endfunction

endpackage

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] din,
    output logic [W-1:0] vec
);
    localparam int unsigned HI = W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec <= '0;
        end else if (ld) begin
            vec <= {din[HI:1], 1'b0};
        end
    end
endmodule

// File: rtl/irq_srv_ctrl.sv
module irq_srv_ctrl
    import irq_chain_pkg::*;
#(
    parameter int unsigned NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_req,
    input  logic            ie_in,
    input  logic            ack,
    input  logic            reti,
    output irq_ctx_t        ctx,
    output logic            bus_own
);
    logic any_src;
    logic ack_start;
    logic eligible;
    logic take;

    assign any_src   = |src_req;
    assign ack_start = ack && !ctx.ack_d;
    assign eligible  = ctx.pend && ie_in && !ctx.in_srv;
    assign take      = ack_start && eligible;
    assign bus_own   = ack && (ctx.claim || take);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else begin
            ctx.ack_d <= ack;
            ctx.claim <= bus_own;
            if (take) begin
                ctx.pend <= 1'b0;
            end else if (any_src) begin
                ctx.pend <= 1'b1;
            end
            if (take) begin
                ctx.in_srv <= 1'b1;
            end else if (reti && ie_in) begin
                ctx.in_srv <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_chain_gate.sv
module irq_chain_gate
    import irq_chain_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         ie_in,
    input  irq_ctx_t     ctx,
    input  logic         bus_own,
    input  logic [W-1:0] vec,
    output logic         ie_out,
    output logic         int_n,
    output logic [W-1:0] dout,
    output logic         dout_en
);
    assign ie_out  = ie_in && !ctx.in_srv && !ctx.pend;
    assign int_n   = !(ctx.pend && ie_in && !ctx.in_srv);
    assign dout_en = bus_own;

    for (genvar i = 0; i < W; i++) begin : g_bus
        assign dout[i] = vec[i] & bus_own;
    end
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
    import irq_chain_pkg::*;
#(
    parameter int unsigned NSRC = NSRC_DEF,
    parameter int unsigned VW   = VEC_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_req,
    input  logic            ie_in,
    input  logic            iorq_n,
    input  logic            m1_n,
    input  logic            rd_n,
    input  logic            vec_ld,
    input  logic [VW-1:0]   cpu_din,
    input  logic            reti_seen,
    output logic            ie_out,
    output logic            int_n,
    output logic [VW-1:0]   dout,
    output logic            dout_en
);
    logic          ack;
    logic          bus_own;
    logic [VW-1:0] vec;
    irq_ctx_t      ctx;

    assign ack = ack_decode(iorq_n, m1_n, rd_n);

    irq_vec_reg #(.W(VW)) u_vec (
        .clk (clk),
        .rst (rst),
        .ld  (vec_ld),
        .din (cpu_din),
        .vec (vec)
    );

    irq_srv_ctrl #(.NSRC(NSRC)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .src_req (src_req),
        .ie_in   (ie_in),
        .ack     (ack),
        .reti    (reti_seen),
        .ctx     (ctx),
        .bus_own (bus_own)
    );

    irq_chain_gate #(.W(VW)) u_gate (
        .ie_in   (ie_in),
        .ctx     (ctx),
        .bus_own (bus_own),
        .vec     (vec),
        .ie_out  (ie_out),
        .int_n   (int_n),
        .dout    (dout),
        .dout_en (dout_en)
    );
endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk #(
    parameter int unsigned VW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ie_in,
    input logic          iorq_n,
    input logic          m1_n,
    input logic          rd_n,
    input logic          ie_out,
    input logic          int_n,
    input logic [VW-1:0] dout,
    input logic          dout_en
);
    p_ieo_needs_iei_r2: assert property (@(posedge clk) disable iff (rst)
        !ie_in |-> !ie_out);

    p_req_needs_iei_r3: assert property (@(posedge clk) disable iff (rst)
        !int_n |-> ie_in);

    p_req_blocks_lower_r4: assert property (@(posedge clk) disable iff (rst)
        !int_n |-> !ie_out);

    p_bus_in_ack_r5: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (!iorq_n && !m1_n && rd_n));

    p_claim_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_en) |=> (!ie_out && int_n));

    p_vec_bit0_r8: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> !dout[0]);

    p_release_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));
endmodule

bind irq_chain_node irq_chain_node_chk #(.VW(VW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ie_in   (ie_in),
    .iorq_n  (iorq_n),
    .m1_n    (m1_n),
    .rd_n    (rd_n),
    .ie_out  (ie_out),
    .int_n   (int_n),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/irq_chain_node_test.sv
module irq_chain_node_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src_req = '0;
    logic       ie_in = 1'b1;
    logic       iorq_n = 1'b1;
    logic       m1_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       vec_ld = 1'b0;
    logic [7:0] cpu_din = '0;
    logic       reti_seen = 1'b0;
    logic       ie_out;
    logic       int_n;
    logic [7:0] dout;
    logic       dout_en;

    typedef struct {
        string      tag;
        logic       intn;
        logic       ieo;
        logic       en;
        logic [7:0] dout;
    } exp_t;

    exp_t q[$];
    int   compared = 0;
    int   mismatched = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    irq_chain_node #(.NSRC(4), .VW(8)) uut (
        .clk       (clk),
        .rst       (rst),
        .src_req   (src_req),
        .ie_in     (ie_in),
        .iorq_n    (iorq_n),
        .m1_n      (m1_n),
        .rd_n      (rd_n),
        .vec_ld    (vec_ld),
        .cpu_din   (cpu_din),
        .reti_seen (reti_seen),
        .ie_out    (ie_out),
        .int_n     (int_n),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    // Monitor: compares the expectation pushed for this cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            compared++;
            if (int_n !== e.intn || ie_out !== e.ieo ||
                dout_en !== e.en || dout !== e.dout) begin
                mismatched++;
                $display("FAIL %s: got int_n=%b ie_out=%b dout_en=%b dout=%h, expected int_n=%b ie_out=%b dout_en=%b dout=%h",
                         e.tag, int_n, ie_out, dout_en, dout,
                         e.intn, e.ieo, e.en, e.dout);
            end
        end
    end

    // Driver: one cycle of stimulus, optional expectation
    task automatic step(input string tag, input logic [3:0] s, input logic iei,
                        input logic iq, input logic m1, input logic rd,
                        input logic rt, input logic ld, input logic [7:0] d,
                        input bit chk, input logic e_intn, input logic e_ieo,
                        input logic e_en, input logic [7:0] e_dout);
        exp_t e;
        @(posedge clk);
        #1;
        src_req = s; ie_in = iei; iorq_n = iq; m1_n = m1; rd_n = rd;
        reti_seen = rt; vec_ld = ld; cpu_din = d;
        if (chk) begin
            e.tag = tag; e.intn = e_intn; e.ieo = e_ieo; e.en = e_en; e.dout = e_dout;
            q.push_back(e);
        end
    endtask

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // tag, src, iei, iorq_n, m1_n, rd_n, reti, ld, din, chk, intn, ieo, en, dout
        step("R1 in reset",      4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 1, 1, 0, 8'h00);
        step("R1 in reset",      4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 0, 1, 1, 0, 8'h00);
        @(posedge clk); #1; rst = 1'b0;
        q.push_back('{"R1 after reset", 1'b1, 1'b1, 1'b0, 8'h00});
        step("R8 load A7",       4'h0, 1, 1, 1, 1, 0, 1, 8'hA7, 1, 1, 1, 0, 8'h00);
        step("R2 iei low",       4'h0, 0, 1, 1, 1, 0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R3 src with iei0", 4'h1, 0, 1, 1, 1, 0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R3 no req iei0",   4'h0, 0, 1, 1, 1, 0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R3 R4 req",        4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
        step("R5 R8 ack start",  4'h0, 1, 0, 0, 1, 0, 0, 8'h00, 1, 0, 0, 1, 8'hA6);
        step("R5 R6 ack hold",   4'h0, 1, 0, 0, 1, 0, 0, 8'h00, 1, 1, 0, 1, 8'hA6);
        step("R9 R6 idle",       4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R6 src in srv",    4'h2, 1, 1, 1, 1, 0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R6 pend masked",   4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R7 reti iei0",     4'h0, 0, 1, 1, 1, 1, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R7 reti ignored",  4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R7 reti iei1",     4'h0, 1, 1, 1, 1, 1, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R7 R4 srv ended",  4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
        step("R9 ack iei0",      4'h0, 0, 0, 0, 1, 0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R9 mid ack",       4'h0, 1, 0, 0, 1, 0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
        step("R3 still req",     4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
        step("R10 ack with src", 4'h4, 1, 0, 0, 1, 0, 0, 8'h00, 1, 0, 0, 1, 8'hA6);
        step("R5 ack hold 2",    4'h0, 1, 0, 0, 1, 0, 0, 8'h00, 1, 1, 0, 1, 8'hA6);
        step("R7 reti 2",        4'h0, 1, 1, 1, 1, 1, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        step("R10 R7 reopened",  4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 1, 1, 0, 8'h00);
        step("R8 load 3F",       4'h0, 1, 1, 1, 1, 0, 1, 8'h3F, 1, 1, 1, 0, 8'h00);
        step("R9 ack no pend",   4'h0, 1, 0, 0, 1, 0, 0, 8'h00, 1, 1, 1, 0, 8'h00);
        step("R3 src",           4'h8, 1, 1, 1, 1, 0, 0, 8'h00, 1, 1, 1, 0, 8'h00);
        step("R3 R4 req 2",      4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
        step("R5 m1 only",       4'h0, 1, 1, 0, 1, 0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
        step("R5 io read",       4'h0, 1, 0, 0, 0, 0, 0, 8'h00, 1, 0, 0, 0, 8'h00);
        step("R5 R8 ack 3E",     4'h0, 1, 0, 0, 1, 0, 0, 8'h00, 1, 0, 0, 1, 8'h3E);
        step("R9 R6 after",      4'h0, 1, 1, 1, 1, 0, 0, 8'h00, 1, 1, 0, 0, 8'h00);
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule